// File: doc/BRIEF.md
# PS/2 Receive Queue Adapter

This block takes the serial clock and data lines of one PS/2 port, rebuilds each device-to-host frame and places the raw byte in a small first-in first-out queue. A host on an 8-bit I/O bus reads the queue through two byte registers, selected by one address bit. The block does not decode the bytes, so the same block serves a keyboard port and a mouse port.

The host polls a status byte until the empty flag clears. It then reads the data byte, which shows the oldest queued byte and leaves the queue as it is. Finally it writes any value to the status location, and that write removes the oldest byte. Frames with a broken start, stop or parity bit are dropped. A partial frame that stalls longer than a timeout is abandoned. A byte that arrives while the queue is full is lost.

Top module: `ps2_rx_queue`

## Requirements
- R1: A read at address bit 0 = 0 returns the status byte: bit 1 is the full flag (queue holds DEPTH bytes), bit 0 is the empty flag (queue holds no byte), and bits 7..2 are zero.
- R2: A read at address bit 0 = 1 returns the oldest queued byte and changes neither the queue contents nor the status.
- R3: A write at address bit 0 = 0 removes the oldest byte, whatever the write data. The next byte then shows at the data location.
- R4: A write at address bit 0 = 1 has no effect on the queue.
- R5: A frame is a 0 start bit, 8 data bits sent least significant bit first, an odd parity bit and a 1 stop bit. Data is sampled on falling edges of the synchronized and filtered PS/2 clock. The data byte is queued unchanged.
- R6: A frame with wrong parity or a stop bit of 0 is discarded.
- R7: If no PS/2 clock falling edge arrives for TIMEOUT cycles during a frame, the partial frame is dropped and the receiver waits for a new start bit.
- R8: A byte received while the queue is full is dropped, and the queued bytes stay unchanged.
- R9: A pop while the queue is empty has no effect. A data read while the queue is empty returns 0x00.
- R10: A synchronous reset empties the queue and clears any partial frame.
- R11: Bytes leave the queue in the order they were received.
- R12: The read bus is 0x00 unless chip select and read strobe are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | PS/2 clock line (asynchronous) |
| ps2_dat_i | input | 1 | PS/2 data line (asynchronous) |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr0 | input | 1 | Register select: 0 = status/pop, 1 = data |
| wdata | input | 8 | Write data (value unused) |
| rdata | output | 8 | Combinational read data |

## Verification
The bench builds the block with DEPTH = 4, FILT = 3 and TIMEOUT = 200. With a depth of four, the full flag and the drop of a fifth byte can be reached after four frames. A 200-cycle timeout lets a stalled partial frame expire in a few hundred cycles. Three filter cycles keep each frame short enough to send many frames, including ones with bad parity or a bad stop bit.

// File: rtl/ps2_rx_queue.sv
module ps2_rx_queue #(
  parameter int DEPTH   = 16,
  parameter int FILT    = 8,
  parameter int TIMEOUT = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr0,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = (FILT > 1) ? $clog2(FILT) : 1;
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [1:0]    ck_sync, dt_sync;
  logic          ck_f;
  logic [FW-1:0] fcnt;
  logic          fall;
  logic [3:0]    bitcnt;
  logic [9:0]    sh;
  logic [TW-1:0] tcnt;
  logic [10:0]   frame;
  logic          frame_ok;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] count;
  logic          full, empty, push, pop;

  wire ck_s = ck_sync[1];
  wire dt_s = dt_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sync <= 2'b11;
      dt_sync <= 2'b11;
      ck_f    <= 1'b1;
      fcnt    <= '0;
    end else begin
      ck_sync <= {ck_sync[0], ps2_clk_i};
      dt_sync <= {dt_sync[0], ps2_dat_i};
      if (ck_s != ck_f) begin
        if (fcnt == FW'(FILT - 1)) begin
          ck_f <= ck_s;
          fcnt <= '0;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end else begin
        fcnt <= '0;
      end
    end
  end

  assign fall     = (ck_s != ck_f) && (fcnt == FW'(FILT - 1)) && !ck_s;
  assign frame    = {dt_s, sh};
  assign frame_ok = fall && (bitcnt == 4'd10) && !frame[0] && frame[10] && (^frame[9:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt <= '0;
      sh     <= '0;
      tcnt   <= '0;
    end else if (fall) begin
      tcnt <= '0;
      sh   <= {dt_s, sh[9:1]};
      if (bitcnt == 4'd10)
        bitcnt <= '0;
      else if (bitcnt != 4'd0 || !dt_s)
        bitcnt <= bitcnt + 1'b1;
    end else if (bitcnt != 4'd0) begin
      if (tcnt == TW'(TIMEOUT - 1)) begin
        bitcnt <= '0;
        tcnt   <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = frame_ok && !full;
  assign pop   = cs && wr && !addr0 && !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= frame[8:1];

  assign rdata = !(cs && rd) ? 8'h00 :
                 !addr0      ? {6'b0, full, empty} :
                 empty       ? 8'h00 : mem[rp];

  wire unused_ok = ^wdata;
endmodule

module ps2_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic          addr0,
  input logic [7:0]    rdata,
  input logic          frame_ok,
  input logic [CW-1:0] count
);
  p_status_hi_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !addr0) |-> (rdata[7:2] == 6'b0));

  p_flags_excl_r1: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !addr0) |-> $onehot0(rdata[1:0]));

  p_peek_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (!(cs && wr && !addr0) && !frame_ok) |=> $stable(count));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && !(cs && wr && !addr0)) |=> (count == CW'(DEPTH)));

  p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !frame_ok) |=> (count == '0));

  p_empty_data_r9: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr0 && count == '0) |-> (rdata == 8'h00));

  p_reset_empty_r10: assert property (@(posedge clk)
    $past(rst) |-> (count == '0));
endmodule

bind ps2_rx_queue ps2_rx_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr0(addr0),
  .rdata(rdata), .frame_ok(frame_ok), .count(count)
);

// File: tb/tb_ps2_rx_queue.sv
module tb_ps2_rx_queue;
  localparam int DEPTH = 4;
  localparam int HALF  = 10;

  logic clk = 0, rst = 1;
  logic ps2c = 1, ps2d = 1;
  logic cs = 0, rd = 0, wr = 0, addr0 = 0;
  logic [7:0] wdata = 0, rdata;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  ps2_rx_queue #(.DEPTH(DEPTH), .FILT(3), .TIMEOUT(200)) dut (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2c), .ps2_dat_i(ps2d),
    .cs(cs), .rd(rd), .wr(wr), .addr0(addr0), .wdata(wdata), .rdata(rdata)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    cs = 1; rd = 1; addr0 = a;
    #1 v = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr0 = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic ps2_bit(input logic b);
    ps2d = b;
    cyc(HALF);
    ps2c = 0;
    cyc(HALF);
    ps2c = 1;
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
    @(negedge clk);
    ps2_bit(1'b0);
    for (int i = 0; i < 8; i++) ps2_bit(b[i]);
    ps2_bit((~^b) ^ bad_par);
    ps2_bit(!bad_stop);
    ps2d = 1;
    cyc(3 * HALF);
  endtask

  task automatic expect_status(input string req, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(1'b0, v);
    check(req, v, exp);
  endtask

  task automatic expect_data(input string req, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(1'b1, v);
    check(req, v, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    cyc(3);
    rst = 0;
    cyc(2);
  endtask

  task automatic t_reset();
    expect_status("R10 status after reset", 8'h01);
    expect_data("R9 data when empty", 8'h00);
  endtask

  task automatic t_single();
    send(8'hA5);
    expect_status("R1 status one byte", 8'h00);
    expect_data("R5 received byte", 8'hA5);
    expect_data("R2 second peek", 8'hA5);
    expect_status("R2 status after peek", 8'h00);
    host_wr(1'b1, 8'h00);
    expect_data("R4 data after write to offset 1", 8'hA5);
    expect_status("R4 status after write to offset 1", 8'h00);
    host_wr(1'b0, 8'h5A);
    expect_status("R3 status after pop", 8'h01);
  endtask

  task automatic t_order();
    send(8'h12); send(8'h80); send(8'h01);
    expect_data("R11 first", 8'h12);
    host_wr(1'b0, 8'hFF);
    expect_data("R3 R11 second", 8'h80);
    host_wr(1'b0, 8'h00);
    expect_data("R11 third", 8'h01);
    host_wr(1'b0, 8'h33);
    expect_status("R3 drained", 8'h01);
  endtask

  task automatic t_bad();
    send(8'h3C, 1, 0);
    expect_status("R6 bad parity dropped", 8'h01);
    send(8'h3C, 0, 1);
    expect_status("R6 bad stop dropped", 8'h01);
    cyc(300);
    send(8'h77);
    expect_data("R6 good frame after bad", 8'h77);
    host_wr(1'b0, 8'h00);
  endtask

  task automatic t_timeout();
    @(negedge clk);
    ps2_bit(1'b0); ps2_bit(1'b1); ps2_bit(1'b1); ps2_bit(1'b0);
    ps2d = 1;
    cyc(400);
    send(8'hC3);
    expect_status("R7 status after timeout", 8'h00);
    expect_data("R7 frame after stall", 8'hC3);
    host_wr(1'b0, 8'h00);
  endtask

  task automatic t_full();
    send(8'h10); send(8'h20); send(8'h30); send(8'h40);
    expect_status("R1 full flag", 8'h02);
    send(8'h50);
    expect_status("R8 still full", 8'h02);
    expect_data("R8 head kept", 8'h10);
    host_wr(1'b0, 8'h00); expect_data("R8 entry 2", 8'h20);
    host_wr(1'b0, 8'h00); expect_data("R8 entry 3", 8'h30);
    host_wr(1'b0, 8'h00); expect_data("R8 entry 4", 8'h40);
    host_wr(1'b0, 8'h00);
    expect_status("R8 no fifth byte", 8'h01);
  endtask

  task automatic t_pop_empty();
    host_wr(1'b0, 8'h00);
    host_wr(1'b0, 8'h00);
    expect_status("R9 pop on empty", 8'h01);
    send(8'h9E);
    expect_data("R9 byte after empty pops", 8'h9E);
    expect_status("R9 count after empty pops", 8'h00);
  endtask

  task automatic t_idle_bus();
    @(negedge clk);
    cs = 0; rd = 1; addr0 = 1;
    #1 check("R12 no cs", rdata, 8'h00);
    cs = 1; rd = 0;
    #1 check("R12 no rd", rdata, 8'h00);
    @(negedge clk);
    cs = 0;
  endtask

  task automatic t_reset_mid();
    send(8'h44);
    @(negedge clk);
    ps2_bit(1'b0); ps2_bit(1'b1); ps2_bit(1'b1);
    ps2d = 1;
    do_reset();
    expect_status("R10 reset empties", 8'h01);
    send(8'h66);
    expect_data("R10 receiver cleared", 8'h66);
    host_wr(1'b0, 8'h00);
  endtask

  initial begin
    cyc(4);
    rst = 0;
    cyc(2);
    t_reset();
    t_single();
    t_order();
    t_bad();
    t_timeout();
    t_full();
    t_pop_empty();
    t_idle_bus();
    t_reset_mid();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule